// File: doc/BRIEF.md
# IO Coherency Window Decoder

This block decides whether the address of an IO or DMA transaction lies inside a single programmable coherency window. A hit steers the transaction to the snooped, coherent path. A miss sends it straight to memory. The snoop logic and the interconnect that act on the decision sit outside the block.

Software programs four fields through a small register port:
- a size exponent,
- a base page number,
- a partial-coherency flag,
- an enable flag.

The window always spans a power-of-two number of bytes and must start on a multiple of its own size. A base that breaks this rule raises a configuration error and suppresses every hit.

Each transaction presents an address with a valid strobe. One clock later the block returns:
- a registered valid echo,
- the hit decision,
- a partial-qualified hit.

Top module: `coh_window_decode`

## Requirements
- R1: After reset all four fields read as zero, and `out_valid`, `coh_hit`, `coh_partial` and `cfg_err` are low.
- R2: A write with `reg_we` high stores `reg_wdata` into the field chosen by `reg_sel`:
  - 0 selects the size exponent (low 5 bits).
  - 1 selects the base page (low ADDR_W-12 bits).
  - 2 selects the partial flag (bit 0).
  - 3 selects the enable flag (bit 0).
  
  `reg_rdata` returns the selected field zero-extended to 32 bits.
- R3: A size value S makes the window 2^(S+2) KB, that is 2^(S+12) bytes. For example, S=0x11 gives 512 MB. An aligned window hits for addresses from its start through start+2^(S+12)-1 and misses just outside that range.
- R4: The base field holds the window start address shifted right by 12, so it counts 4 KB pages. The smallest window, S=0, is one 4 KB page.
- R5: With the enable flag at 0, no transaction produces a hit.
- R6: If the base has any nonzero bit below bit position S, `cfg_err` goes high one cycle after the offending write and `coh_hit` stays low. `cfg_err` goes low again one cycle after the base or size is corrected.
- R7: A size of ADDR_W-12 or more saturates to the whole address space. With base 0 every address hits; any nonzero base is then misaligned and raises `cfg_err`.
- R8: `coh_partial` equals `coh_hit` ANDed with the partial flag, and it is never high without `coh_hit`.
- R9: The `out_valid`, `coh_hit` and `coh_partial` outputs are registered. They reflect the transaction sampled at the previous clock edge, and `out_valid` echoes `txn_valid` with one cycle of delay.
- R10: A transaction sampled on the same clock edge as a register write is decoded with the old configuration. The write applies from the next transaction on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Field select: 0 size, 1 base, 2 partial, 3 enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Selected field, zero-extended |
| txn_valid | input | 1 | Transaction address valid |
| txn_addr | input | ADDR_W | Transaction byte address |
| out_valid | output | 1 | Registered echo of txn_valid |
| coh_hit | output | 1 | Transaction falls in the window (route coherent) |
| coh_partial | output | 1 | Hit with partial-coherency flag set |
| cfg_err | output | 1 | Window base not aligned to window size |

## Verification
A corrupted size or base field shows at the ports one cycle after the next transaction. It appears as a wrong hit at a window edge: the first or last byte inside, or the first byte outside. It also shows immediately on `reg_rdata`. A stale alignment check shows as `cfg_err` holding its old value on the cycle after a base or size write. A misordered update shows as a transaction on the same edge as a write picking up the new setting.

// File: rtl/coh_window_decode.sv
module coh_window_decode #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              txn_valid,
  input  logic [ADDR_W-1:0] txn_addr,
  output logic              out_valid,
  output logic              coh_hit,
  output logic              coh_partial,
  output logic              cfg_err
);
  localparam int PW = ADDR_W - 12;

  logic [SIZE_W-1:0] size_q;
  logic [PW-1:0]     base_q;
  logic              part_q, en_q;
  logic [PW-1:0]     low_m;
  logic              misal, match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      base_q <= '0;
      part_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (reg_we) begin
      case (reg_sel)
        2'd0: size_q <= reg_wdata[SIZE_W-1:0];
        2'd1: base_q <= reg_wdata[PW-1:0];
        2'd2: part_q <= reg_wdata[0];
        default: en_q <= reg_wdata[0];
      endcase
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0: reg_rdata = 32'(size_q);
      2'd1: reg_rdata = 32'(base_q);
      2'd2: reg_rdata = {31'd0, part_q};
      default: reg_rdata = {31'd0, en_q};
    endcase
  end

  always_comb begin
    for (int i = 0; i < PW; i++)
      low_m[i] = (i < int'(size_q));
  end

  assign misal = |(base_q & low_m);
  assign match = (((txn_addr[ADDR_W-1:12] ^ base_q) & ~low_m) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      coh_hit     <= 1'b0;
      coh_partial <= 1'b0;
      cfg_err     <= 1'b0;
    end else begin
      out_valid   <= txn_valid;
      coh_hit     <= txn_valid & en_q & ~misal & match;
      coh_partial <= txn_valid & en_q & ~misal & match & part_q;
      cfg_err     <= misal;
    end
  end

  AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    coh_hit |-> $past(en_q)); // R5
  AST_HIT_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    coh_hit |-> !cfg_err); // R6
  AST_PART_IN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    coh_partial |-> coh_hit); // R8
  AST_HIT_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    coh_hit |-> out_valid); // R9
  AST_VALID_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> out_valid); // R9
endmodule

// File: tb/test_coh_window_decode.sv
module test_coh_window_decode;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [1:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        txn_valid = 0;
  logic [31:0] txn_addr = 0;
  logic        out_valid, coh_hit, coh_partial, cfg_err;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  coh_window_decode i_coh_window_decode (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic txn(string req, logic [31:0] a, logic eh, logic ep);
    @(negedge clk); txn_valid = 1; txn_addr = a;
    @(negedge clk); txn_valid = 0;
    chk(req, {29'd0, out_valid, coh_hit, coh_partial}, {29'd0, 1'b1, eh, ep});
  endtask

  task automatic t_reset();
    for (int s = 0; s < 4; s++) begin
      reg_sel = 2'(s); #0.1;
      chk("R1 field", reg_rdata, 0);
    end
    chk("R1 outs", {28'd0, out_valid, coh_hit, coh_partial, cfg_err}, 0);
  endtask

  task automatic t_regs();
    wr(0, 32'hFFFF_FF11); reg_sel = 0; #0.1; chk("R2 size", reg_rdata, 32'h11);
    wr(1, 32'hFFF2_0000); reg_sel = 1; #0.1; chk("R2 base", reg_rdata, 32'h2_0000);
    wr(2, 32'h0000_0002); reg_sel = 2; #0.1; chk("R2 part", reg_rdata, 0);
    wr(3, 32'h0000_0003); reg_sel = 3; #0.1; chk("R2 en", reg_rdata, 1);
  endtask

  task automatic t_window();
    txn("R3 first", 32'h2000_0000, 1, 0);
    txn("R3 last", 32'h3FFF_FFFF, 1, 0);
    txn("R3 above", 32'h4000_0000, 0, 0);
    txn("R3 below", 32'h1FFF_FFFF, 0, 0);
    wr(0, 0); wr(1, 32'h12345);
    txn("R4 page in", 32'h1234_5FFF, 1, 0);
    txn("R4 page next", 32'h1234_6000, 0, 0);
    txn("R4 page prev", 32'h1234_4FFF, 0, 0);
  endtask

  task automatic t_partial();
    wr(2, 1);
    txn("R8 part hit", 32'h1234_5000, 1, 1);
    txn("R8 part miss", 32'h0000_0000, 0, 0);
    wr(2, 0);
  endtask

  task automatic t_enable();
    wr(3, 0);
    txn("R5 disabled", 32'h1234_5000, 0, 0);
    wr(3, 1);
    txn("R5 enabled", 32'h1234_5000, 1, 0);
  endtask

  task automatic t_misalign();
    wr(0, 32'h11); wr(1, 32'h2_1000);
    @(negedge clk); chk("R6 err set", {31'd0, cfg_err}, 1);
    txn("R6 hit forced low", 32'h2000_0000, 0, 0);
    wr(1, 32'h2_0000);
    @(negedge clk); chk("R6 err clear", {31'd0, cfg_err}, 0);
    txn("R6 hit back", 32'h2000_0000, 1, 0);
  endtask

  task automatic t_saturate();
    wr(0, 20); wr(1, 0);
    txn("R7 top", 32'hFFFF_FFFF, 1, 0);
    txn("R7 zero", 32'h0, 1, 0);
    wr(0, 31);
    txn("R7 max size", 32'h8000_1234, 1, 0);
    wr(1, 1);
    @(negedge clk); chk("R7 err", {31'd0, cfg_err}, 1);
    txn("R7 no hit", 32'h0, 0, 0);
  endtask

  task automatic t_order();
    wr(0, 0); wr(1, 32'h5);
    @(negedge clk);
    txn_valid = 1; txn_addr = 32'h5000; reg_we = 1; reg_sel = 3; reg_wdata = 0;
    @(negedge clk); txn_valid = 0; reg_we = 0;
    chk("R10 old cfg", {30'd0, out_valid, coh_hit}, 32'h3);
    txn("R10 new cfg", 32'h5000, 0, 0);
    @(negedge clk); chk("R9 valid drops", {31'd0, out_valid}, 0);
  endtask

  initial begin
    #500000;
    fails++; checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #10; t_reset();
    @(negedge clk); rst_n = 1;
    t_regs();
    t_window();
    t_partial();
    t_enable();
    t_misalign();
    t_saturate();
    t_order();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule